// File: doc/BRIEF.md
# CVSD Bitstream Word FIFO Pair

This block sits between a peripheral bus and a serial CVSD converter core that handles one bit per sample. On the receive side, the bus writes 16-bit words into an eight-word FIFO. A serializer loads each word and hands its bits to the core one at a time, one bit per strobe. The core takes bit 0, the oldest sample, first and bit 15, the newest sample, last. On the transmit side, a deserializer collects the bits that the core produces one per strobe into 16-bit words, places the last bit of each word in bit 15, and pushes each completed word into a second eight-word FIFO. The bus reads the words from that FIFO.

Four sticky status flags record underrun and overflow on both paths. A status read clears them. A debug freeze input stops all transfers on the core side. While freeze is high, a status read does not clear the flags. Bus writes and bus reads still work while freeze is high.

Top module: `cvsd_word_fifo_pair`

## Requirements
- R1: The input FIFO holds 8 words. A bus write that arrives while it holds 8 words is dropped and sets status bit 1 (input full).
- R2: Once a word is loaded, `core_in_valid` is high and `core_in_bit` shows bit 0 of that word. Each accepted strobe advances to the next higher bit. After the strobe that consumes bit 15, the next FIFO word is loaded in the same cycle if one is present.
- R3: A core input strobe while `core_in_valid` is low consumes nothing and sets status bit 0 (input empty).
- R4: On the output path, the first strobed bit of a word ends up in bit 0 and the 16th in bit 15. The word is pushed into the output FIFO on the 16th strobe.
- R5: The output FIFO holds 8 words. A word completed while it holds 8 words is dropped and sets status bit 3 (output full).
- R6: A bus read from an empty output FIFO leaves `out_rd_data` at its previous value, moves no pointer and sets status bit 2 (output empty). A read from a non-empty FIFO places the oldest word on `out_rd_data` in the following cycle.
- R7: Both FIFOs preserve word order.
- R8: While `freeze` is high, core strobes on both paths are ignored: no bit is consumed, no bit is collected, and no word is loaded into the serializer.
- R9: With `freeze` low, a status read clears all four flags after they are presented. With `freeze` high, a status read leaves them set.
- R10: After reset, all flags are zero, `core_in_valid` is low and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Debug halt of core-side transfers and of the clear-on-read |
| in_wr_en | input | 1 | Bus write strobe for the input FIFO |
| in_wr_data | input | 16 | Bus write word |
| out_rd_en | input | 1 | Bus read strobe for the output FIFO |
| out_rd_data | output | 16 | Last word read from the output FIFO |
| stat_rd_en | input | 1 | Status read strobe (clears flags when not frozen) |
| stat_flags | output | 4 | Sticky flags: bit0 in empty, bit1 in full, bit2 out empty, bit3 out full |
| core_in_strobe | input | 1 | Core takes the presented input bit |
| core_in_bit | output | 1 | Current input bit for the core |
| core_in_valid | output | 1 | `core_in_bit` holds a real sample |
| core_out_strobe | input | 1 | Core delivers an output bit |
| core_out_bit | input | 1 | Output bit from the core |

## Verification
The assertions assume that a status read does not fall in the same cycle as a flag-setting event. They also assume that the core strobes and the bus strobes are single-cycle levels sampled at the clock. The bench drives every strobe for exactly one cycle and leaves idle cycles after bus writes so that the serializer can load. It takes each status snapshot in a cycle with no other traffic. Randomized batches never exceed the FIFO depth unless the overflow case is intended.

// File: rtl/cvsd_fifo_pkg.sv
// Shared constants for the CVSD word FIFO pair.
package cvsd_fifo_pkg;
    localparam int WORD_W     = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int NUM_FLAGS  = 4;
    // Status flag positions, decoded by software.
    localparam int FLG_IN_EMPTY  = 0;
    localparam int FLG_IN_FULL   = 1;
    localparam int FLG_OUT_EMPTY = 2;
    localparam int FLG_OUT_FULL  = 3;
endpackage

// File: rtl/cvsd_word_fifo.sv
// Synchronous word FIFO with an occupancy count.
// Assumes: a push while full and a pop while empty are ignored by the FIFO itself.
module cvsd_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [W-1:0]                     wdata,
    input  logic                             pop,
    output logic [W-1:0]                     head,
    output logic                             full,
    output logic                             empty,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH-1);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/cvsd_bit_serializer.sv
// Input-path serializer: loads a word from the FIFO, presents bit 0 first,
// advances one bit per strobe and reloads after bit W-1.
// Assumes: strobe is a one-cycle request; freeze stops every state change.
module cvsd_bit_serializer #(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     freeze,
    input  logic                     strobe,
    input  logic                     fifo_empty,
    input  logic [W-1:0]             fifo_head,
    output logic                     fifo_pop,
    output logic                     bit_out,
    output logic                     bit_valid,
    output logic                     underrun,
    output logic [W-1:0]             shreg_o,
    output logic [$clog2(W)-1:0]     bitcnt_o
);
    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(W-1);

    logic [W-1:0]    shreg;
    logic [CNTW-1:0] bitcnt;
    logic            loaded;
    logic            consume, need_word;

    // Decide consumption and reload for this cycle.
    always_comb begin
        consume   = strobe && loaded && !freeze;
        need_word = !loaded || (consume && bitcnt == LAST_BIT);
        fifo_pop  = !freeze && need_word && !fifo_empty;
        underrun  = strobe && !loaded && !freeze;
    end

    // Shift register, bit counter and loaded state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            loaded <= 1'b0;
        end else if (!freeze) begin
            if (fifo_pop) begin
                shreg  <= fifo_head;
                bitcnt <= '0;
                loaded <= 1'b1;
            end else if (consume) begin
                shreg <= shreg >> 1;
                if (bitcnt == LAST_BIT) begin
                    bitcnt <= '0;
                    loaded <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    assign bit_out   = shreg[0];
    assign bit_valid = loaded;
    assign shreg_o   = shreg;
    assign bitcnt_o  = bitcnt;
endmodule

// File: rtl/cvsd_bit_deserializer.sv
// Output-path deserializer: shifts each strobed bit in at the top so the
// first bit of a word lands in bit 0; emits the word on the W-th strobe.
// Assumes: strobe is a one-cycle request; freeze discards strobes.
module cvsd_bit_deserializer #(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     freeze,
    input  logic                     strobe,
    input  logic                     bit_in,
    output logic                     word_push,
    output logic [W-1:0]             word_out,
    output logic [$clog2(W)-1:0]     bitcnt_o
);
    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(W-1);

    logic [W-1:0]    acc;
    logic [CNTW-1:0] bitcnt;
    logic            take;

    // Form the word that completes on this strobe.
    always_comb begin
        take      = strobe && !freeze;
        word_out  = {bit_in, acc[W-1:1]};
        word_push = take && (bitcnt == LAST_BIT);
    end

    // Accumulator and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            bitcnt <= '0;
        end else if (take) begin
            acc    <= word_out;
            bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
        end
    end

    assign bitcnt_o = bitcnt;
endmodule

// File: rtl/cvsd_status_flags.sv
// Sticky status flags: set by events, cleared by a status read unless frozen.
// Assumes: a set in the same cycle as a clear wins.
module cvsd_status_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         rd_clear,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    logic clr;
    assign clr = rd_clear && !freeze;

    // Hold, clear on read, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | set;
    end
endmodule

// File: rtl/cvsd_word_fifo_pair.sv
// Top: input word FIFO plus serializer, deserializer plus output word FIFO,
// and sticky status flags with clear-on-read.
// Assumes: bus and core strobes are one-cycle pulses on clk.
module cvsd_word_fifo_pair
    import cvsd_fifo_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 freeze,
    input  logic                 in_wr_en,
    input  logic [W-1:0]         in_wr_data,
    input  logic                 out_rd_en,
    output logic [W-1:0]         out_rd_data,
    input  logic                 stat_rd_en,
    output logic [NUM_FLAGS-1:0] stat_flags,
    input  logic                 core_in_strobe,
    output logic                 core_in_bit,
    output logic                 core_in_valid,
    input  logic                 core_out_strobe,
    input  logic                 core_out_bit
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int CNTW = $clog2(W);

    logic [W-1:0]         in_head, out_head, out_word;
    logic                 in_fifo_full, in_fifo_empty, in_pop;
    logic                 out_fifo_full, out_fifo_empty, out_push, out_pop;
    logic [CW-1:0]        in_fifo_count, out_fifo_count;
    logic [W-1:0]         in_shreg;
    logic [CNTW-1:0]      in_bitcnt, out_bitcnt;
    logic                 in_underrun;
    logic [NUM_FLAGS-1:0] flag_set;

    cvsd_word_fifo #(.W(W), .DEPTH(DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(in_wr_en), .wdata(in_wr_data), .pop(in_pop),
        .head(in_head), .full(in_fifo_full), .empty(in_fifo_empty),
        .count(in_fifo_count)
    );

    cvsd_bit_serializer #(.W(W)) u_ser (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .strobe(core_in_strobe),
        .fifo_empty(in_fifo_empty), .fifo_head(in_head), .fifo_pop(in_pop),
        .bit_out(core_in_bit), .bit_valid(core_in_valid),
        .underrun(in_underrun), .shreg_o(in_shreg), .bitcnt_o(in_bitcnt)
    );

    cvsd_bit_deserializer #(.W(W)) u_deser (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .strobe(core_out_strobe),
        .bit_in(core_out_bit), .word_push(out_push), .word_out(out_word),
        .bitcnt_o(out_bitcnt)
    );

    cvsd_word_fifo #(.W(W), .DEPTH(DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .wdata(out_word), .pop(out_pop),
        .head(out_head), .full(out_fifo_full), .empty(out_fifo_empty),
        .count(out_fifo_count)
    );

    // Gather flag-setting events from both paths.
    always_comb begin
        out_pop                 = out_rd_en && !out_fifo_empty;
        flag_set                = '0;
        flag_set[FLG_IN_EMPTY]  = in_underrun;
        flag_set[FLG_IN_FULL]   = in_wr_en && in_fifo_full;
        flag_set[FLG_OUT_EMPTY] = out_rd_en && out_fifo_empty;
        flag_set[FLG_OUT_FULL]  = out_push && out_fifo_full;
    end

    // Bus read data register; holds its value on an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_rd_data <= '0;
        else if (out_pop) out_rd_data <= out_head;
    end

    cvsd_status_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .rd_clear(stat_rd_en),
        .set(flag_set), .flags(stat_flags)
    );
endmodule

// File: rtl/cvsd_fifo_pair_checker.sv
// Assertion checker for cvsd_word_fifo_pair, bound to every instance.
module cvsd_fifo_pair_checker #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         freeze,
    input logic                         in_wr_en,
    input logic                         out_rd_en,
    input logic [W-1:0]                 out_rd_data,
    input logic                         stat_rd_en,
    input logic [3:0]                   stat_flags,
    input logic                         core_in_strobe,
    input logic                         core_in_bit,
    input logic                         core_in_valid,
    input logic                         core_out_strobe,
    input logic                         in_fifo_full,
    input logic                         out_fifo_empty,
    input logic                         out_fifo_full,
    input logic [$clog2(DEPTH+1)-1:0]   in_fifo_count,
    input logic [$clog2(DEPTH+1)-1:0]   out_fifo_count,
    input logic [W-1:0]                 in_shreg,
    input logic [$clog2(W)-1:0]         in_bitcnt,
    input logic [$clog2(W)-1:0]         out_bitcnt
);
    localparam logic [$clog2(W)-1:0] LAST_BIT = ($clog2(W))'(W-1);

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_fifo_count <= ($clog2(DEPTH+1))'(DEPTH) && out_fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    p_full_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_wr_en && in_fifo_full |=> stat_flags[1]);

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_in_strobe && core_in_valid && !freeze && in_bitcnt != LAST_BIT
        |=> core_in_valid && core_in_bit == $past(in_shreg[1]));

    p_underrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_in_strobe && !core_in_valid && !freeze |=> stat_flags[0]);

    p_word_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_strobe && !freeze && out_bitcnt == LAST_BIT && !out_fifo_full && !out_rd_en
        |=> out_fifo_count == $past(out_fifo_count) + 1'b1);

    p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_strobe && !freeze && out_bitcnt == LAST_BIT && out_fifo_full |=> stat_flags[3]);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_rd_en && out_fifo_empty |=> $stable(out_rd_data) && stat_flags[2]);

    p_freeze_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(core_in_valid) && $stable(in_shreg) && $stable(in_bitcnt));

    p_freeze_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(out_bitcnt));

    p_freeze_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && stat_rd_en |=> (stat_flags & $past(stat_flags)) == $past(stat_flags));
endmodule

bind cvsd_word_fifo_pair cvsd_fifo_pair_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .in_wr_en(in_wr_en),
    .out_rd_en(out_rd_en), .out_rd_data(out_rd_data), .stat_rd_en(stat_rd_en),
    .stat_flags(stat_flags), .core_in_strobe(core_in_strobe),
    .core_in_bit(core_in_bit), .core_in_valid(core_in_valid),
    .core_out_strobe(core_out_strobe), .in_fifo_full(in_fifo_full),
    .out_fifo_empty(out_fifo_empty), .out_fifo_full(out_fifo_full),
    .in_fifo_count(in_fifo_count), .out_fifo_count(out_fifo_count),
    .in_shreg(in_shreg), .in_bitcnt(in_bitcnt), .out_bitcnt(out_bitcnt)
);

// File: tb/tb_cvsd_word_fifo_pair.sv
module tb_cvsd_word_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        in_wr_en = 1'b0;
    logic [15:0] in_wr_data = '0;
    logic        out_rd_en = 1'b0;
    logic [15:0] out_rd_data;
    logic        stat_rd_en = 1'b0;
    logic [3:0]  stat_flags;
    logic        core_in_strobe = 1'b0;
    logic        core_in_bit, core_in_valid;
    logic        core_out_strobe = 1'b0;
    logic        core_out_bit = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cvsd_word_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .in_wr_en(in_wr_en), .in_wr_data(in_wr_data),
        .out_rd_en(out_rd_en), .out_rd_data(out_rd_data),
        .stat_rd_en(stat_rd_en), .stat_flags(stat_flags),
        .core_in_strobe(core_in_strobe), .core_in_bit(core_in_bit),
        .core_in_valid(core_in_valid), .core_out_strobe(core_out_strobe),
        .core_out_bit(core_out_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] w);
        @(negedge clk); in_wr_en = 1'b1; in_wr_data = w;
        @(negedge clk); in_wr_en = 1'b0;
    endtask

    // Returns the read word, sampled one cycle after the request.
    task automatic bus_read(output logic [15:0] w);
        @(negedge clk); out_rd_en = 1'b1;
        @(negedge clk); out_rd_en = 1'b0; w = out_rd_data;
    endtask

    // Returns the flags presented before the read takes effect.
    task automatic stat_read(output logic [3:0] f);
        @(negedge clk); f = stat_flags; stat_rd_en = 1'b1;
        @(negedge clk); stat_rd_en = 1'b0;
    endtask

    task automatic take_bit(input string req, input logic exp);
        @(negedge clk);
        check(req, {31'd0, core_in_valid}, 32'd1);
        check(req, {31'd0, core_in_bit}, {31'd0, exp});
        core_in_strobe = 1'b1;
        @(negedge clk); core_in_strobe = 1'b0;
    endtask

    task automatic give_bit(input logic b);
        @(negedge clk); core_out_strobe = 1'b1; core_out_bit = b;
        @(negedge clk); core_out_strobe = 1'b0;
    endtask

    task automatic take_word(input string req, input logic [15:0] w);
        for (int i = 0; i < 16; i++) take_bit(req, w[i]);
    endtask

    task automatic give_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) give_bit(w[i]);
    endtask

    // Expected word after splicing: low half from a, high half from b.
    function automatic logic [15:0] splice(input logic [15:0] a, input logic [15:0] b);
        return {b[15:8], a[7:0]};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [3:0]  f;
        logic [15:0] w, last;
        logic [15:0] q [$];
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10: reset state
        check("R10 flags", {28'd0, stat_flags}, 32'd0);
        check("R10 valid", {31'd0, core_in_valid}, 32'd0);

        // R3: underrun strobe, then R9 clear
        @(negedge clk); core_in_strobe = 1'b1;
        @(negedge clk); core_in_strobe = 1'b0;
        stat_read(f); check("R3 in empty flag", {28'd0, f}, 32'h1);
        stat_read(f); check("R9 cleared", {28'd0, f}, 32'h0);

        // R1/R7/R9: overflow under freeze, flags kept while frozen
        freeze = 1'b1;
        for (int i = 0; i < 9; i++) bus_write(16'hA000 + 16'(i * 16'h0111));
        idle(2);
        check("R8 no load while frozen", {31'd0, core_in_valid}, 32'd0);
        stat_read(f); check("R1 in full flag", {28'd0, f}, 32'h2);
        stat_read(f); check("R9 kept under freeze", {28'd0, f}, 32'h2);
        freeze = 1'b0;
        stat_read(f); check("R9 after freeze", {28'd0, f}, 32'h2);
        stat_read(f); check("R9 cleared after freeze", {28'd0, f}, 32'h0);
        idle(2);
        for (int i = 0; i < 8; i++) take_word("R2/R7 order", 16'hA000 + 16'(i * 16'h0111));
        idle(1);
        check("R1 ninth dropped", {31'd0, core_in_valid}, 32'd0);

        // R8: freeze mid-word on input path
        bus_write(16'b1011_0110_1100_1010);
        idle(3);
        w = 16'b1011_0110_1100_1010;
        for (int i = 0; i < 3; i++) take_bit("R2 bits", w[i]);
        freeze = 1'b1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); core_in_strobe = 1'b1;
            @(negedge clk); core_in_strobe = 1'b0;
        end
        freeze = 1'b0;
        for (int i = 3; i < 16; i++) take_bit("R8 input held", w[i]);

        // R4/R6: pack and empty read
        give_word(16'h8001);
        bus_read(last); check("R4 packing", {16'd0, last}, 32'h8001);
        bus_read(w); check("R6 empty read holds", {16'd0, w}, {16'd0, last});
        stat_read(f); check("R6 out empty flag", {28'd0, f}, 32'h4);

        // R5: output overflow
        for (int i = 0; i < 9; i++) give_word(16'h1234 + 16'(i));
        stat_read(f); check("R5 out full flag", {28'd0, f}, 32'h8);
        for (int i = 0; i < 8; i++) begin
            bus_read(w); check("R5/R7 out order", {16'd0, w}, {16'd0, 16'h1234 + 16'(i)});
        end
        bus_read(w); check("R5 ninth dropped", {16'd0, w}, 32'h123B);

        // R8: freeze on output path splits a word
        stat_read(f);
        for (int i = 0; i < 8; i++) give_bit(1'(16'h3C5A >> i));
        freeze = 1'b1;
        for (int i = 0; i < 8; i++) give_bit(1'b1);
        freeze = 1'b0;
        for (int i = 8; i < 16; i++) give_bit(1'(16'hE700 >> i));
        bus_read(w); check("R8 output held", {16'd0, w}, {16'd0, splice(16'h3C5A, 16'hE700)});

        // Random batches on both paths
        for (int it = 0; it < 20; it++) begin
            int n;
            n = 1 + int'($urandom_range(7));
            q.delete();
            for (int i = 0; i < n; i++) begin
                w = 16'($urandom);
                q.push_back(w);
                bus_write(w);
            end
            idle(3);
            for (int i = 0; i < n; i++) take_word("R2 random", q[i]);
            q.delete();
            for (int i = 0; i < n; i++) begin
                w = 16'($urandom);
                q.push_back(w);
                give_word(w);
            end
            for (int i = 0; i < n; i++) begin
                bus_read(w); check("R4 random", {16'd0, w}, {16'd0, q[i]});
            end
            stat_read(f); check("R7 no stray flags", {28'd0, f}, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule